// File: doc/BRIEF.md
# Programmable 8-bit timer/event counter

This block is an up-counter with a reload register. A two-bit mode field picks what advances it. In event mode it counts edges on an external pin. In timer mode it counts strobes of an internal tick enable. In pulse-width mode it counts ticks for as long as the pin holds a chosen level. Software reaches it through a small register port with four word addresses. The count address is asymmetric: a write lands in the reload register, and a read returns the running count.

When the count passes its maximum value, the counter reloads from the reload register. In the same cycle it raises a sticky interrupt request and inverts a square-wave output. With reload value N and a steady tick, that output therefore has a period of 2×(256−N) ticks. The pin is resynchronised inside the block, so it may be fully asynchronous.

Top module: `evtimer_top`

## Requirements
- R1: After reset the control address (1) reads 0x08, and the count address (0), the flag address (2), `irq_o` and `pfd_o` all read 0.
- R2: A write to address 0 goes only to the reload register and leaves the count unchanged. A read of address 0 returns the live count.
- R3: Control bits [7:6] select the mode: 00 off, 01 event, 10 timer, 11 pulse width. Bit 4 enables counting, and bit 3 selects the edge. With mode 00 nothing counts, even when the enable bit is 1.
- R4: In event mode each active pin edge adds one to the count: rising when bit 3 = 1, falling when bit 3 = 0. The count shows the edge no later than four clocks after the pin changes. `tick_i` has no effect in this mode.
- R5: In timer mode every clock in which `tick_i` is high adds one to the count.
- R6: A step taken at count 0xFF loads the reload value into the counter and sets the interrupt flag in the same cycle.
- R7: `pfd_o` inverts on every overflow and at no other time. The first overflow from reset comes after 256 ticks, and each later one after 256−N ticks.
- R8: In pulse-width mode the active edge starts a measurement: rising if bit 3 = 1, falling if 0. The count then rises on each tick while the pin stays at the active level. The opposite edge ends the measurement and clears the enable bit in hardware. A pulse held for W clocks with `tick_i` high gives a count of W, and later pulses change nothing.
- R9: The flag (address 2, bit 0) stays at 1 until software writes 0 to bit 0 of address 2. Writing 1 has no effect. If an overflow and a clearing write fall in the same cycle, the flag stays at 1.
- R10: With the enable bit at 0 the count does not move, and the reload register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register word address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| tmr_pin_i | input | 1 | External event / pulse input (asynchronous) |
| tick_i | input | 1 | Internal time-base enable, one clock wide per tick |
| irq_o | output | 1 | Sticky overflow interrupt request |
| pfd_o | output | 1 | Square wave that inverts on each overflow |

## Verification
The assertions assume that bus writes are single-cycle strobes with a stable address and data. They also assume that software, not the counter, changes the control register, except where a pulse-width measurement finishes. The count-upward property assumes that `tick_i` and the pin are the only sources of steps.

The bench drives each bus write for exactly one rising edge. It changes the pin and `tick_i` only on falling edges, and it holds the pin steady for several clocks before it enables a mode. As a result, no edge caused by reset or a mode change enters a measurement. Pulse widths and reload values are swept over small ranges, and the expected counts and periods are computed arithmetically.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } mode_e;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_FLAG  = 2'd2;

  // control register bit positions
  localparam int unsigned CTRL_MODE_LSB = 6;
  localparam int unsigned CTRL_EN_BIT   = 4;
  localparam int unsigned CTRL_ESEL_BIT = 3;
endpackage

// File: rtl/evtimer_sync.sv
module evtimer_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= pin_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/evtimer_regs.sv
module evtimer_regs
  import evtimer_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              ovf_i,
  input  logic              pw_done_i,
  output mode_e             mode_o,
  output logic              en_o,
  output logic              esel_o,
  output logic [CNT_W-1:0]  preload_o,
  output logic              flag_o
);
  logic wr_count, wr_ctrl, wr_flag;

  assign wr_count = we_i && (addr_i == ADDR_W'(ADDR_COUNT));
  assign wr_ctrl  = we_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_flag  = we_i && (addr_i == ADDR_W'(ADDR_FLAG));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       preload_o <= '0;
    else if (wr_count) preload_o <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mode_o <= MODE_OFF;
      en_o   <= 1'b0;
      esel_o <= 1'b1;
    end else if (wr_ctrl) begin
      mode_o <= mode_e'(wdata_i[CTRL_MODE_LSB +: 2]);
      en_o   <= wdata_i[CTRL_EN_BIT];
      esel_o <= wdata_i[CTRL_ESEL_BIT];
    end else if (pw_done_i) begin
      en_o   <= 1'b0;
    end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                      flag_o <= 1'b0;
    else if (ovf_i)                   flag_o <= 1'b1;
    else if (wr_flag && !wdata_i[0])  flag_o <= 1'b0;
endmodule

// File: rtl/evtimer_core.sv
module evtimer_core
  import evtimer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             en_i,
  input  logic             esel_i,
  input  logic             tick_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] preload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             pw_done_o,
  output logic             pfd_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic act_edge, end_edge, pw_run_q, step;

  assign act_edge = esel_i ? rise_i : fall_i;
  assign end_edge = esel_i ? fall_i : rise_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                 pw_run_q <= 1'b0;
    else if (!en_i || mode_i != MODE_PULSE)      pw_run_q <= 1'b0;
    else if (pw_run_q && end_edge)               pw_run_q <= 1'b0;
    else if (!pw_run_q && act_edge)              pw_run_q <= 1'b1;

  assign pw_done_o = en_i && (mode_i == MODE_PULSE) && pw_run_q && end_edge;

  always_comb begin
    unique case (mode_i)
      MODE_EVENT: step = act_edge;
      MODE_TIMER: step = tick_i;
      MODE_PULSE: step = pw_run_q && tick_i;
      default:    step = 1'b0;
    endcase
    step = step && en_i;
  end

  assign ovf_o = step && (cnt_o == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    cnt_o <= '0;
    else if (ovf_o) cnt_o <= preload_i;
    else if (step)  cnt_o <= cnt_o + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    pfd_o <= 1'b0;
    else if (ovf_o) pfd_o <= ~pfd_o;
endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
  import evtimer_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic              tmr_pin_i,
  input  logic              tick_i,
  output logic              irq_o,
  output logic              pfd_o
);
  mode_e            mode;
  logic             en, esel, flag, ovf, pw_done;
  logic             pin_lvl, pin_rise, pin_fall;
  logic [CNT_W-1:0] preload, cnt;

  evtimer_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (tmr_pin_i),
    .level_o(pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  evtimer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (bus_addr_i),
    .we_i     (bus_we_i),
    .wdata_i  (bus_wdata_i),
    .ovf_i    (ovf),
    .pw_done_i(pw_done),
    .mode_o   (mode),
    .en_o     (en),
    .esel_o   (esel),
    .preload_o(preload),
    .flag_o   (flag)
  );

  evtimer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .en_i     (en),
    .esel_i   (esel),
    .tick_i   (tick_i),
    .rise_i   (pin_rise),
    .fall_i   (pin_fall),
    .preload_i(preload),
    .cnt_o    (cnt),
    .ovf_o    (ovf),
    .pw_done_o(pw_done),
    .pfd_o    (pfd_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      ADDR_W'(ADDR_COUNT): bus_rdata_o = cnt;
      ADDR_W'(ADDR_CTRL): begin
        bus_rdata_o[CTRL_MODE_LSB +: 2] = mode;
        bus_rdata_o[CTRL_EN_BIT]        = en;
        bus_rdata_o[CTRL_ESEL_BIT]      = esel;
      end
      ADDR_W'(ADDR_FLAG): bus_rdata_o[0] = flag;
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o = flag;

  // level is only consumed through the edge strobes
  logic unused_lvl;
  assign unused_lvl = pin_lvl;
endmodule

// File: rtl/evtimer_chk.sv
module evtimer_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic              clr_bit_i,
  input logic              irq_o,
  input logic              pfd_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  preload,
  input logic              ovf,
  input logic              en,
  input logic              pw_done
);
  logic clr_wr, ctrl_wr, pre_wr;
  assign clr_wr  = bus_we_i && (bus_addr_i == ADDR_W'(2)) && !clr_bit_i;
  assign ctrl_wr = bus_we_i && (bus_addr_i == ADDR_W'(1));
  assign pre_wr  = bus_we_i && (bus_addr_i == ADDR_W'(0));

  AST_RELOAD_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> cnt == $past(preload)); // R6
  AST_FLAG_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> irq_o); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_wr) |=> irq_o); // R9
  AST_PFD_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> pfd_o != $past(pfd_o)); // R7
  AST_PFD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf |=> $stable(pfd_o)); // R7
  AST_FREEZE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> $stable(cnt)); // R10
  AST_PRELOAD_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_wr |=> $stable(preload)); // R2
  AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1))); // R3
  AST_PW_SELF_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pw_done && !ctrl_wr) |=> !en); // R8
endmodule

bind evtimer_top evtimer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_addr_i(bus_addr_i),
  .bus_we_i  (bus_we_i),
  .clr_bit_i (bus_wdata_i[0]),
  .irq_o     (irq_o),
  .pfd_o     (pfd_o),
  .cnt       (cnt),
  .preload   (preload),
  .ovf       (ovf),
  .en        (en),
  .pw_done   (pw_done)
);

// File: tb/evtimer_top_tb.sv
`timescale 1ns/1ps
module evtimer_top_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       pin = 1'b0;
  logic       tick = 1'b0;
  logic       irq, pfd;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  evtimer_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(bus_addr), .bus_we_i(bus_we),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .tmr_pin_i(pin),
    .tick_i(tick), .irq_o(irq), .pfd_o(pfd)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  // wait for the next pfd change; returns clocks elapsed
  task automatic wait_pfd(output int cyc);
    logic last;
    last = pfd;
    cyc = 0;
    do begin
      @(posedge clk); #1;
      cyc++;
    end while (pfd == last && cyc < 600);
  endtask

  task automatic pw_case(input int w, input bit pol);
    int v;
    pin = ~pol;
    do_reset();
    wr(2'd1, pol ? 8'hD8 : 8'hD0);
    tick = 1'b1;
    repeat (3) @(negedge clk);
    pin = pol;
    repeat (w) @(negedge clk);
    pin = ~pol;
    repeat (8) @(negedge clk);
    rd(2'd0, v);  check("R8 width", v, w);
    rd(2'd1, v);  check("R8 enable cleared", v, pol ? 8'hC8 : 8'hC0);
    pin = pol;
    repeat (4) @(negedge clk);
    pin = ~pol;
    repeat (8) @(negedge clk);
    rd(2'd0, v);  check("R8 later pulse ignored", v, w);
    tick = 1'b0;
  endtask

  task automatic evt_case(input bit esel);
    int v;
    pin = 1'b0;
    do_reset();
    tick = 1'b1; // must not count in event mode
    wr(2'd1, esel ? 8'h58 : 8'h50);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk) pin = 1'b1;
      repeat (3) @(negedge clk);
      if (i < 6) pin = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(2'd0, v);
    check(esel ? "R4 rising edges" : "R4 falling edges", v, esel ? 7 : 6);
    tick = 1'b0;
    pin = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int v, cyc;
    logic [7:0] nlist [8];
    nlist = '{8'h00, 8'h01, 8'h02, 8'h07, 8'h80, 8'hC3, 8'hFE, 8'hFF};

    // R1 reset state
    do_reset();
    rd(2'd1, v); check("R1 ctrl reset", v, 8'h08);
    rd(2'd0, v); check("R1 count reset", v, 0);
    rd(2'd2, v); check("R1 flag reset", v, 0);
    check("R1 irq reset", irq, 0);
    check("R1 pfd reset", pfd, 0);

    // R2 preload write does not touch the count
    wr(2'd0, 8'h5A);
    rd(2'd0, v); check("R2 write goes to preload", v, 0);

    // R5 timer mode
    wr(2'd1, 8'h98);
    pulses(20);
    rd(2'd0, v); check("R5 timer ticks", v, 20);
    pulses(13);
    rd(2'd0, v); check("R5 timer ticks more", v, 33);

    // R10 freeze
    wr(2'd1, 8'h88);
    pulses(10);
    rd(2'd0, v); check("R10 frozen", v, 33);

    // R3 mode off with enable set
    wr(2'd1, 8'h18);
    pulses(10);
    rd(2'd0, v); check("R3 mode off", v, 33);

    // R10 preload retained; R6 reload + flag
    wr(2'd1, 8'h98);
    bus_addr = 2'd0;
    tick = 1'b1;
    wait_pfd(cyc);
    check("R7 first overflow from 33", cyc, 256 - 33);
    check("R10 preload kept / R6 reload", bus_rdata, 8'h5A);
    check("R6 flag set", irq, 1);
    @(negedge clk) tick = 1'b0;

    // R9 flag handling
    wr(2'd2, 8'h01);
    rd(2'd2, v); check("R9 write 1 no effect", v, 1);
    wr(2'd2, 8'h00);
    rd(2'd2, v); check("R9 cleared", v, 0);
    wr(2'd0, 8'hFF);
    tick = 1'b1;
    repeat (300) @(negedge clk);
    wr(2'd2, 8'h00);
    rd(2'd2, v); check("R9 overflow beats clear", v, 1);
    tick = 1'b0;
    wr(2'd2, 8'h00);
    rd(2'd2, v); check("R9 clear when idle", v, 0);

    // R6/R7 reload sweep
    foreach (nlist[k]) begin
      do_reset();
      tick = 1'b1;
      wr(2'd0, nlist[k]);
      wr(2'd1, 8'h98);
      bus_addr = 2'd0;
      wait_pfd(cyc);
      check("R7 first period 256", cyc, 256);
      check("R6 reload value", bus_rdata, nlist[k]);
      check("R6 flag", irq, 1);
      for (int j = 0; j < 3; j++) begin
        wait_pfd(cyc);
        check("R7 half period 256-N", cyc, 256 - nlist[k]);
      end
      @(negedge clk) tick = 1'b0;
    end

    // R4 event mode both polarities
    evt_case(1'b1);
    evt_case(1'b0);

    // R8 pulse width sweep
    for (int w = 1; w <= 12; w++) begin
      pw_case(w, 1'b1);
      pw_case(w, 1'b0);
    end
    pw_case(200, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule